// File: doc/BRIEF.md
# Status Register Protection Controller

This block keeps the eight-bit status register of a 512 KB serial flash and decides whether each write request may proceed. It sits behind the command decoder, which hands it one decoded request per cycle. The request kinds are: latch enable, latch disable, status write with a data byte, status read, page program, 4 KB sector erase, 64 KB block erase and whole-array erase. Address-bearing requests carry a 19-bit byte address.

It answers each request one cycle later with a grant or deny pulse. It also returns a flag telling whether the request's address fell inside the protected region. The protected region comes from a top/bottom select and three level bits. A lock bit freezes the protection fields while the write-protect pin is held low. The array timer reports the end of an operation through a single-cycle done input. The protection bits are stored as plain flops with a parameterised power-up value.

Top module: `flash_status_guard`

## Requirements
- R1: After a synchronous reset, `status_o` equals the power-up value (0x00 by default), and `grant_o`, `deny_o` and `prot_hit_o` are 0.
- R2: A granted enable request (kind 0) sets the write-enable bit (bit 1), and a granted disable request (kind 1) clears it.
- R3: A status write (kind 2), program (kind 4), sector erase (kind 5), block erase (kind 6) or array erase (kind 7) is refused while bit 1 is 0. A refused request leaves `status_o` unchanged.
- R4: A status write is refused when `wp_n` is 0 and the lock bit (bit 7) is 1. It is accepted when `wp_n` is 1 or the lock bit is 0. While `wp_n` is 0 the lock bit never goes from 1 to 0. One accepted write may set the lock and change the level bits together.
- R5: Status layout: bit0 busy, bit1 write enable, bits 4:2 level bits L2:L0, bit5 bottom-select, bit6 always 0, bit7 lock. A status write loads bits 7 and 5:2 from data bits 7 and 5:2. Data bits 6, 1 and 0 are ignored.
- R6: With L2=1 the whole range 0x00000–0x7FFFF is protected. With L2:L0=000 nothing is protected.
- R7: With bottom-select 0, levels 001, 010 and 011 protect 0x70000–0x7FFFF, 0x60000–0x7FFFF and 0x40000–0x7FFFF.
- R8: With bottom-select 1, levels 001, 010 and 011 protect 0x00000–0x0FFFF, 0x00000–0x1FFFF and 0x00000–0x3FFFF.
- R9: Program, sector erase and block erase are refused when the addressed page, sector (bits 18:12) or block (bits 18:16) lies in the protected range. `prot_hit_o` reports that result one cycle after any of these three kinds.
- R10: Array erase is refused unless L2:L0 are all 0.
- R11: A granted write-type request sets busy (bit 0) on the same edge that raises `grant_o`. `op_done` while busy clears both busy and write enable.
- R12: While busy, every request except a status read (kind 3) is refused. A status read is always granted.
- R13: Every request produces exactly one of `grant_o` or `deny_o` as a one-cycle pulse on the next cycle. Neither pulses without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A decoded request is present this cycle |
| req_kind | input | 3 | Request kind, encoded as in the requirements |
| req_data | input | 8 | Data byte for a status write |
| req_addr | input | 19 | Byte address for program and erase requests |
| wp_n | input | 1 | Write-protect pin level, low enables the lock |
| op_done | input | 1 | Single-cycle end-of-operation pulse from the array timer |
| status_o | output | 8 | Current status byte |
| grant_o | output | 1 | Previous request was accepted |
| deny_o | output | 1 | Previous request was refused |
| prot_hit_o | output | 1 | Previous address-bearing request hit the protected range |

## Verification
The bound checker checks several rules on every cycle: grant and deny are exclusive and silent without a request, and bit 6 stays 0. A write is never granted without the enable bit, and never granted while busy. An array erase is never granted with non-zero level bits. A granted write raises busy at once, and done clears busy and enable. The lock bit cannot fall while the pin is low. The actual protected-address map for each level and each side can only be shown by the bench's scenarios, as can the exact bytes loaded by a status write and the power-up value. Each scenario aims a request at an address just inside or just outside a range boundary.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  typedef enum logic [2:0] {
    K_WEN   = 3'd0,
    K_WDIS  = 3'd1,
    K_WSTAT = 3'd2,
    K_RSTAT = 3'd3,
    K_PROG  = 3'd4,
    K_SECT  = 3'd5,
    K_BLK   = 3'd6,
    K_CHIP  = 3'd7
  } req_kind_e;

  // status bit positions
  localparam int unsigned S_BUSY = 0;
  localparam int unsigned S_WEN  = 1;
  localparam int unsigned S_L0   = 2;
  localparam int unsigned S_BOT  = 5;
  localparam int unsigned S_RSV  = 6;
  localparam int unsigned S_LOCK = 7;

  function automatic logic is_write_kind(req_kind_e k);
    return (k == K_WSTAT) || (k == K_PROG) || (k == K_SECT) ||
           (k == K_BLK) || (k == K_CHIP);
  endfunction

  function automatic logic has_addr(req_kind_e k);
    return (k == K_PROG) || (k == K_SECT) || (k == K_BLK);
  endfunction
endpackage

// File: rtl/sr_guard_range.sv
module sr_guard_range #(
  parameter int unsigned BLK_W = 3
) (
  input  logic [BLK_W-1:0] blk_idx,
  input  logic [2:0]       level,
  input  logic             bottom,
  output logic             hit
);
  localparam int unsigned NBLK = 1 << BLK_W;

  logic [BLK_W:0] span;
  logic [BLK_W:0] idx_ext;

  always_comb begin
    idx_ext = {1'b0, blk_idx};
    // levels 1..3 cover 1/8, 1/4, 1/2 of the array
    span = (BLK_W+1)'(NBLK >> (4 - int'(level[1:0])));
    if (level[2])
      hit = 1'b1;
    else if (level[1:0] == 2'b00)
      hit = 1'b0;
    else if (bottom)
      hit = idx_ext < span;
    else
      hit = idx_ext >= ((BLK_W+1)'(NBLK) - span);
  end
endmodule

// File: rtl/sr_guard_perm.sv
module sr_guard_perm
  import sr_guard_pkg::*;
(
  input  logic      req_valid,
  input  req_kind_e kind,
  input  logic      busy,
  input  logic      wen,
  input  logic      wp_n,
  input  logic      lock,
  input  logic [2:0] level,
  input  logic      hit,
  output logic      allow,
  output logic      start_op
);
  always_comb begin
    allow = 1'b0;
    if (req_valid) begin
      unique case (kind)
        K_RSTAT:             allow = 1'b1;
        K_WEN, K_WDIS:       allow = !busy;
        K_WSTAT:             allow = !busy && wen && (wp_n || !lock);
        K_PROG, K_SECT, K_BLK: allow = !busy && wen && !hit;
        K_CHIP:              allow = !busy && wen && (level == 3'b000);
        default:             allow = 1'b0;
      endcase
    end
    start_op = allow && is_write_kind(kind);
  end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned BLK_LSB = 16,
  parameter logic [7:0]  NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [7:0]        req_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wp_n,
  input  logic              op_done,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              prot_hit_o
);
  localparam int unsigned BLK_W = ADDR_W - BLK_LSB;

  req_kind_e  kind;
  logic       busy_q, wen_q, bot_q, lock_q;
  logic [2:0] lvl_q;
  logic       hit, allow, start_op;

  assign kind = req_kind_e'(req_kind);

  sr_guard_range #(.BLK_W(BLK_W)) u_range (
    .blk_idx (req_addr[ADDR_W-1:BLK_LSB]),
    .level   (lvl_q),
    .bottom  (bot_q),
    .hit     (hit)
  );

  sr_guard_perm u_perm (
    .req_valid (req_valid),
    .kind      (kind),
    .busy      (busy_q),
    .wen       (wen_q),
    .wp_n      (wp_n),
    .lock      (lock_q),
    .level     (lvl_q),
    .hit       (hit),
    .allow     (allow),
    .start_op  (start_op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      wen_q      <= 1'b0;
      lvl_q      <= NV_INIT[S_L0 +: 3];
      bot_q      <= NV_INIT[S_BOT];
      lock_q     <= NV_INIT[S_LOCK];
      grant_o    <= 1'b0;
      deny_o     <= 1'b0;
      prot_hit_o <= 1'b0;
    end else begin
      grant_o    <= req_valid && allow;
      deny_o     <= req_valid && !allow;
      prot_hit_o <= req_valid && has_addr(kind) && hit;
      if (op_done && busy_q) begin
        busy_q <= 1'b0;
        wen_q  <= 1'b0;
      end
      if (allow) begin
        unique case (kind)
          K_WEN:   wen_q <= 1'b1;
          K_WDIS:  wen_q <= 1'b0;
          K_WSTAT: begin
            lvl_q  <= req_data[S_L0 +: 3];
            bot_q  <= req_data[S_BOT];
            lock_q <= req_data[S_LOCK];
          end
          default: ;
        endcase
      end
      if (start_op) busy_q <= 1'b1;
    end
  end

  assign status_o = {lock_q, 1'b0, bot_q, lvl_q, wen_q, busy_q};
endmodule

// File: rtl/sr_guard_checker.sv
module sr_guard_checker
  import sr_guard_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       wp_n,
  input logic       op_done,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       deny_o
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && deny_o)); // R13

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(req_valid) |-> !grant_o && !deny_o); // R13

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[S_RSV] == 1'b0); // R5

  AST_WEN_NEEDED: assert property (@(posedge clk) disable iff (rst)
    past_ok && grant_o && is_write_kind(req_kind_e'($past(req_kind)))
    |-> $past(status_o[S_WEN])); // R3

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(status_o[S_BUSY]) && $past(req_valid) &&
    ($past(req_kind) != 3'(K_RSTAT)) |-> deny_o); // R12

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    past_ok && grant_o && is_write_kind(req_kind_e'($past(req_kind)))
    |-> status_o[S_BUSY]); // R11

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_done && status_o[S_BUSY])
    |-> !status_o[S_BUSY] && !status_o[S_WEN]); // R11

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(status_o[S_LOCK] && !wp_n) |-> status_o[S_LOCK]); // R4

  AST_CHIP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    past_ok && grant_o && ($past(req_kind) == 3'(K_CHIP))
    |-> $past(status_o[4:2]) == 3'b000); // R10
endmodule

bind flash_status_guard sr_guard_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .wp_n      (wp_n),
  .op_done   (op_done),
  .status_o  (status_o),
  .grant_o   (grant_o),
  .deny_o    (deny_o)
);

// File: tb/flash_status_guard_test.sv
`timescale 1ns/1ps
module flash_status_guard_test;
  import sr_guard_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [7:0]  req_data;
  logic [18:0] req_addr;
  logic        wp_n;
  logic        op_done;
  logic [7:0]  status_o;
  logic        grant_o, deny_o, prot_hit_o;

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  flash_status_guard uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_data(req_data), .req_addr(req_addr), .wp_n(wp_n), .op_done(op_done),
    .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o),
    .prot_hit_o(prot_hit_o)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  k;
    logic [7:0]  d;
    logic [18:0] a;
    logic        wp;
    logic        done;
    logic        g;
    logic        h;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd2, 8'hFF, 19'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // 0  R3 status write without enable
    '{1'b1, 3'd4, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // 1  R3 R6 program without enable
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02}, // 2  R2
    '{1'b1, 3'd1, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // 3  R2
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02}, // 4  R2
    '{1'b1, 3'd2, 8'h44, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h07}, // 5  R5 R11 bit6 of data ignored
    '{1'b1, 3'd3, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h07}, // 6  R12 read while busy
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h07}, // 7  R12 enable while busy
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h04}, // 8  R11 R13 done clears
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06}, // 9
    '{1'b1, 3'd4, 8'h00, 19'h7FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 8'h06}, // 10 R7 top 1/8
    '{1'b1, 3'd4, 8'h00, 19'h6FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h07}, // 11 R7 just below
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h04}, // 12
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06}, // 13
    '{1'b1, 3'd2, 8'h0C, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F}, // 14 R4 top half
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0C}, // 15
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0E}, // 16
    '{1'b1, 3'd4, 8'h00, 19'h40000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0E}, // 17 R7 R9 edge of top half
    '{1'b1, 3'd4, 8'h00, 19'h3FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F}, // 18 R7 R9
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0C}, // 19
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0E}, // 20
    '{1'b1, 3'd2, 8'h28, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2B}, // 21 R8 bottom 1/4
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h28}, // 22
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2A}, // 23
    '{1'b1, 3'd5, 8'h00, 19'h1F000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2A}, // 24 R8 R9 sector in range
    '{1'b1, 3'd6, 8'h00, 19'h2ABCD, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2B}, // 25 R8 R9 block outside
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h28}, // 26
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h2A}, // 27
    '{1'b1, 3'd7, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h2A}, // 28 R10 levels nonzero
    '{1'b1, 3'd2, 8'h9C, 19'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9F}, // 29 R4 lock plus levels, pin low
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h9C}, // 30
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9E}, // 31
    '{1'b1, 3'd4, 8'h00, 19'h00010, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9E}, // 32 R6 whole array
    '{1'b1, 3'd2, 8'h00, 19'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h9E}, // 33 R4 locked
    '{1'b1, 3'd2, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h03}, // 34 R4 pin high unlocks
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // 35
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02}, // 36
    '{1'b1, 3'd7, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h03}, // 37 R10 levels zero
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // 38
    '{1'b1, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02}, // 39
    '{1'b1, 3'd4, 8'h00, 19'h7FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h03}, // 40 R6 nothing protected
    '{1'b0, 3'd0, 8'h00, 19'h00000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, // 41
    '{1'b1, 3'd3, 8'h00, 19'h00000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}  // 42 R12 read when idle
  };

  task automatic chk(input string what, input int idx,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (step %0d): actual=%h expected=%h", what, idx, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_kind = 3'd0; req_data = 8'h00;
    req_addr = '0; op_done = 1'b0;
  endtask

  initial begin
    rst = 1'b1; wp_n = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", -1, status_o, 8'h00);
    chk("R1 reset grant", -1, {7'd0, grant_o}, 8'h00);
    chk("R1 reset deny", -1, {7'd0, deny_o}, 8'h00);
    chk("R1 reset hit", -1, {7'd0, prot_hit_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      req_valid = VEC[i].v;
      req_kind  = VEC[i].k;
      req_data  = VEC[i].d;
      req_addr  = VEC[i].a;
      wp_n      = VEC[i].wp;
      op_done   = VEC[i].done;
      @(negedge clk);
      chk("R13 grant", i, {7'd0, grant_o}, {7'd0, VEC[i].g});
      chk("R13 deny", i, {7'd0, deny_o}, {7'd0, VEC[i].v & ~VEC[i].g});
      chk("R9 prot_hit", i, {7'd0, prot_hit_o}, {7'd0, VEC[i].h});
      chk("R5 status", i, status_o, VEC[i].st);
    end
    idle_inputs();

    // R1 reset while busy with lock set and pin low
    wp_n = 1'b1;
    req_valid = 1'b1; req_kind = 3'(K_WEN);
    @(negedge clk);
    req_kind = 3'(K_WSTAT); req_data = 8'hBC;
    @(negedge clk);
    idle_inputs();
    wp_n = 1'b0;
    chk("R4 locked setup", 100, status_o, 8'hBF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-operation", 101, status_o, 8'h00);

    // R13 no pulse with no request over several cycles
    repeat (3) @(negedge clk);
    chk("R13 quiet", 102, {6'd0, grant_o, deny_o}, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule